// File: doc/BRIEF.md
# Timer Capture and Edge-Count Input Conditioner

This block sits between one external timer input pin and a timer's main counter. It brings the pin into the clock domain, finds its edges, and serves two roles at once. First, it produces a count-enable tick. In timer mode the tick is high on every clock. In the three counter modes it pulses once for each selected edge of the pin. Second, it acts as an edge-qualified capture trigger. On a rising and/or falling edge, it copies the counter value presented to it into a capture register. It then sets a sticky capture flag, which can drive an interrupt line.

The main counter is not part of this block. The counter consumes `tick_o` and feeds its present value back on `count_i`. Software-visible fields arrive as plain control inputs. Clearing the flag is a one-cycle write-one pulse.

Top module: `capcnt_unit`

## Requirements
- R1: After a synchronous active-low reset, `cap_value_o` is 0, `cap_flag_o` is 0 and `cap_irq_o` is 0.
- R2: With `cnt_mode_i` = 0 (timer mode), `tick_o` is 1 in every cycle.
- R3: With `cnt_mode_i` = 1, `tick_o` pulses for one cycle per rising edge of the pin. With 2 it pulses per falling edge, and with 3 it pulses per edge of either polarity. It is 0 in all other cycles.
- R4: The pin goes through a two-flop synchronizer followed by one history flop. A level change first sampled at clock edge n is reported, as a tick or a capture trigger, in the cycle between edges n+1 and n+2.
- R5: When `cap_en_i` = 1 and the detected edge matches an enabled polarity (`cap_rise_en_i` for rising, `cap_fall_en_i` for falling), `cap_value_o` loads the `count_i` of that cycle at the next clock edge and `cap_flag_o` sets.
- R6: When `cap_en_i` = 0, no edge changes `cap_value_o` or sets `cap_flag_o`, whatever the edge enables are.
- R7: When `cap_en_i` = 1 and both edge enables are 0, no capture happens and `cap_flag_o` never sets.
- R8: `cap_flag_o` stays set until a cycle with `flag_clr_i` = 1 and no capture. If a capture and a clear fall in the same cycle, the flag stays set.
- R9: `cap_irq_o` is 1 exactly when `cap_flag_o` is 1 and `cap_irq_en_i` is 1.
- R10: Only input-select code 0 (`in_sel_i` = 0) routes the pin. With any other code, the counter modes give no ticks and no capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Asynchronous external capture/count pin |
| count_i | input | CNT_W | Present value of the main counter |
| cnt_mode_i | input | 2 | 0 timer, 1 rising, 2 falling, 3 both edges |
| in_sel_i | input | 2 | Count input select; only 0 routes the pin |
| cap_rise_en_i | input | 1 | Capture on rising edges |
| cap_fall_en_i | input | 1 | Capture on falling edges |
| cap_irq_en_i | input | 1 | Let the capture flag drive the interrupt |
| cap_en_i | input | 1 | Master enable for capture |
| flag_clr_i | input | 1 | Write-one clear pulse for the capture flag |
| tick_o | output | 1 | Count-enable for the main counter |
| cap_value_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |
| cap_irq_o | output | 1 | Capture interrupt request |

## Verification
The flag can be set by a capture and cleared by software in the same cycle, and R8 decides which one wins. To provoke this, the bench toggles the pin randomly with both capture polarities enabled while it pulses the clear on about half the cycles. Many captures therefore land in clear cycles. The behavioural model lets the set win. It compares flag, interrupt, value and tick on every clock, and it counts the coincidences so that the run shows the case was actually reached.

// File: rtl/capcnt_pkg.sv
// Shared encodings for the capture/count input conditioner.
package capcnt_pkg;

    // Count source: timer or one of three pin-edge choices.
    typedef enum logic [1:0] {
        CM_TIMER = 2'd0,
        CM_RISE  = 2'd1,
        CM_FALL  = 2'd2,
        CM_BOTH  = 2'd3
    } cnt_mode_e;

    // The only supported input-select code.
    localparam logic [1:0] SEL_PIN0 = 2'd0;

    // One-cycle edge strobes from the conditioned pin.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

endpackage

// File: rtl/cap_sync_edge.sv
// Synchronizes the asynchronous pin and emits one-cycle edge strobes.
// Assumes STAGES >= 2. The strobes are combinational from the last
// synchronizer stage and a history flop.
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_i,
    output capcnt_pkg::edge_t    edge_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          hist_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], pin_i};
    end

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= sync_q[LAST];
    end

    // Compare the new and previous levels.
    always_comb begin
        edge_o.rise = sync_q[LAST] & ~hist_q;
        edge_o.fall = ~sync_q[LAST] & hist_q;
    end
endmodule

// File: rtl/cap_count_gate.sv
// Turns the selected count source into a count-enable tick.
// Assumes the edge strobes are already qualified by the input select.
module cap_count_gate (
    input  logic               [1:0] mode_i,
    input  capcnt_pkg::edge_t        edge_i,
    output logic                     tick_o
);
    import capcnt_pkg::*;

    // Decode the count mode into a tick.
    always_comb begin
        case (cnt_mode_e'(mode_i))
            CM_TIMER: tick_o = 1'b1;
            CM_RISE:  tick_o = edge_i.rise;
            CM_FALL:  tick_o = edge_i.fall;
            default:  tick_o = edge_i.rise | edge_i.fall;
        endcase
    end
endmodule

// File: rtl/cap_latch.sv
// Capture register and sticky flag. A qualifying edge loads the counter
// value of the same cycle. A capture outranks a simultaneous clear.
module cap_latch #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  capcnt_pkg::edge_t    edge_i,
    input  logic [CNT_W-1:0]     count_i,
    input  logic                 rise_en_i,
    input  logic                 fall_en_i,
    input  logic                 cap_en_i,
    input  logic                 irq_en_i,
    input  logic                 clr_i,
    output logic [CNT_W-1:0]     value_o,
    output logic                 flag_o,
    output logic                 irq_o
);
    logic fire;

    // Qualify the edge by polarity enables and the master enable.
    always_comb begin
        fire = cap_en_i & ((edge_i.rise & rise_en_i) | (edge_i.fall & fall_en_i));
    end

    // Load the captured count.
    always_ff @(posedge clk) begin
        if (!rst_n)    value_o <= '0;
        else if (fire) value_o <= count_i;
    end

    // Sticky flag: set by capture, cleared by write-one when not capturing.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (fire)  flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // Gate the flag onto the interrupt line.
    always_comb begin
        irq_o = flag_o & irq_en_i;
    end
endmodule

// File: rtl/capcnt_unit.sv
// Top of the capture/count input conditioner. It routes one pin through
// the synchronizer, then into the count gate and the capture latch.
// Assumes the main counter consumes tick_o and returns its value on count_i.
module capcnt_unit #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       cnt_mode_i,
    input  logic [1:0]       in_sel_i,
    input  logic             cap_rise_en_i,
    input  logic             cap_fall_en_i,
    input  logic             cap_irq_en_i,
    input  logic             cap_en_i,
    input  logic             flag_clr_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cap_value_o,
    output logic             cap_flag_o,
    output logic             cap_irq_o
);
    import capcnt_pkg::*;

    edge_t raw_edge;
    edge_t sel_edge;
    logic  sel_ok;

    cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .edge_o (raw_edge)
    );

    // Only select code 0 passes the pin's edges (R10).
    always_comb begin
        sel_ok        = (in_sel_i == SEL_PIN0);
        sel_edge.rise = raw_edge.rise & sel_ok;
        sel_edge.fall = raw_edge.fall & sel_ok;
    end

    cap_count_gate u_gate (
        .mode_i (cnt_mode_i),
        .edge_i (sel_edge),
        .tick_o (tick_o)
    );

    cap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (sel_edge),
        .count_i   (count_i),
        .rise_en_i (cap_rise_en_i),
        .fall_en_i (cap_fall_en_i),
        .cap_en_i  (cap_en_i),
        .irq_en_i  (cap_irq_en_i),
        .clr_i     (flag_clr_i),
        .value_o   (cap_value_o),
        .flag_o    (cap_flag_o),
        .irq_o     (cap_irq_o)
    );
endmodule

// File: rtl/capcnt_unit_chk.sv
// Port-level properties of capcnt_unit, attached by bind.
module capcnt_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cnt_mode_i,
    input logic [1:0]       in_sel_i,
    input logic             cap_rise_en_i,
    input logic             cap_fall_en_i,
    input logic             cap_en_i,
    input logic             flag_clr_i,
    input logic             tick_o,
    input logic [CNT_W-1:0] cap_value_o,
    input logic             cap_flag_o
);
    assert_timer_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode_i == 2'd0) |-> tick_o);

    assert_off_holds_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(cap_value_o));

    assert_no_edge_en_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_rise_en_i && !cap_fall_en_i && !cap_flag_o) |=> !cap_flag_o);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cap_en_i) |=> !cap_flag_o);

    assert_bad_sel_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode_i != 2'd0 && in_sel_i != 2'd0) |-> !tick_o);
endmodule

bind capcnt_unit capcnt_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_mode_i    (cnt_mode_i),
    .in_sel_i      (in_sel_i),
    .cap_rise_en_i (cap_rise_en_i),
    .cap_fall_en_i (cap_fall_en_i),
    .cap_en_i      (cap_en_i),
    .flag_clr_i    (flag_clr_i),
    .tick_o        (tick_o),
    .cap_value_o   (cap_value_o),
    .cap_flag_o    (cap_flag_o)
);

// File: tb/capcnt_unit_bench.sv
module capcnt_unit_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin = 1'b0;
    logic [W-1:0] count = '0;
    logic [1:0]   mode = 2'd0, sel = 2'd0;
    logic         re = 1'b0, fe = 1'b0, ie = 1'b0, ce = 1'b0, clr = 1'b0;
    logic         tick;
    logic [W-1:0] cval;
    logic         flag, irq;

    int n_tests = 0, n_fail = 0, n_coinc = 0, n_caps = 0, n_ticks = 0;
    bit done = 1'b0;

    // Reference state
    bit           hist[$] = '{1'b0, 1'b0, 1'b0};
    bit [W-1:0]   m_val = '0;
    bit           m_flag = 1'b0;

    always #4 clk = ~clk;

    capcnt_unit #(.CNT_W(W)) u_capcnt_unit (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(count),
        .cnt_mode_i(mode), .in_sel_i(sel), .cap_rise_en_i(re),
        .cap_fall_en_i(fe), .cap_irq_en_i(ie), .cap_en_i(ce),
        .flag_clr_i(clr), .tick_o(tick), .cap_value_o(cval),
        .cap_flag_o(flag), .cap_irq_o(irq)
    );

    // Behavioural model, advanced on each clock edge.
    always @(posedge clk) begin
        bit r, f, cap;
        if (!rst_n) begin
            hist = '{1'b0, 1'b0, 1'b0};
            m_val = '0;
            m_flag = 1'b0;
        end else begin
            r = hist[1] && !hist[2];
            f = !hist[1] && hist[2];
            cap = (sel == 2'd0) && ce && ((r && re) || (f && fe));
            if (cap) begin
                m_val = count; m_flag = 1'b1; n_caps++;
                if (clr) n_coinc++;
            end else if (clr) m_flag = 1'b0;
            hist.push_front(pin);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model; call right after a falling edge.
    task automatic compare();
        bit r, f, t;
        r = hist[1] && !hist[2];
        f = !hist[1] && hist[2];
        if (sel != 2'd0) begin r = 1'b0; f = 1'b0; end
        case (mode)
            2'd0: t = 1'b1;
            2'd1: t = r;
            2'd2: t = f;
            default: t = r || f;
        endcase
        if (mode != 2'd0 && t) n_ticks++;
        chk(mode == 2'd0 ? "R2 tick" : (sel != 2'd0 ? "R10 tick" : "R3/R4 tick"), W'(tick), W'(t));
        chk(ce ? "R5 value" : "R6 value", cval, m_val);
        chk((!re && !fe) ? "R7 flag" : "R8 flag", W'(flag), W'(m_flag));
        chk("R9 irq", W'(irq), W'(m_flag && ie));
    endtask

    // Run one phase: pstyle 0 random, 1 toggle every 3 cycles, 2 hold.
    // cstyle 0 never clear, 1 random clear, 2 clear on first cycle.
    task automatic phase(input logic [1:0] m, input logic [1:0] s, input logic r_en,
                         input logic f_en, input logic c_en, input logic i_en,
                         input int pstyle, input int cstyle, input int n);
        mode = m; sel = s; re = r_en; fe = f_en; ce = c_en; ie = i_en;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            count = count + W'(1) + W'($urandom_range(0, 5));
            case (pstyle)
                0: pin = 1'($urandom_range(0, 1));
                1: if (i % 3 == 0) pin = ~pin;
                default: ;
            endcase
            case (cstyle)
                1: clr = 1'($urandom_range(0, 1));
                2: clr = (i == 0);
                default: clr = 1'b0;
            endcase
        end
        clr = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 value", cval, '0);
        chk("R1 flag", W'(flag), '0);
        chk("R1 irq", W'(irq), '0);

        phase(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 40);    // R2 timer mode
        phase(2'd1, 2'd0, 0, 0, 0, 0, 1, 0, 60);    // R3 rising count, R4 latency
        phase(2'd2, 2'd0, 0, 0, 0, 0, 0, 0, 60);    // R3 falling count
        phase(2'd3, 2'd0, 0, 0, 0, 0, 0, 0, 60);    // R3 both edges
        phase(2'd1, 2'd0, 1, 0, 1, 1, 1, 0, 60);    // R5 rising capture, R9
        phase(2'd0, 2'd0, 1, 0, 1, 1, 2, 2, 30);    // R8 clear then hold
        phase(2'd2, 2'd0, 0, 1, 1, 0, 0, 2, 60);    // R5 falling capture, R9 masked
        phase(2'd3, 2'd0, 1, 1, 0, 1, 0, 0, 60);    // R6 capture off
        phase(2'd3, 2'd0, 0, 0, 1, 1, 0, 2, 60);    // R7 no edge enables
        phase(2'd1, 2'd1, 1, 1, 1, 1, 0, 2, 60);    // R10 bad select
        phase(2'd3, 2'd0, 1, 1, 1, 1, 0, 1, 400);   // R8 capture vs clear
        phase(2'd3, 2'd0, 1, 1, 1, 1, 2, 0, 10);    // R8 sticky after hold

        // R8: the coincidence must have been reached
        n_tests++;
        if (n_coinc == 0) begin
            n_fail++;
            $display("FAIL R8 coincidences actual=0 expected>0");
        end
        // R5: captures must have happened
        n_tests++;
        if (n_caps == 0) begin
            n_fail++;
            $display("FAIL R5 captures actual=0 expected>0");
        end
        // R3: counter-mode ticks must have happened
        n_tests++;
        if (n_ticks == 0) begin
            n_fail++;
            $display("FAIL R3 ticks actual=0 expected>0");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule